// File: doc/BRIEF.md
# Clock Generator Power-Down and Mode Sequencer

This block sits beside the synthesizer of a system clock generator and decides when the generator's clocks may run. An asynchronous, active-low power-down pin is passed through a flop synchronizer. Once a request is seen, the block first gates the processor, bus and reference clocks low. It then holds them parked for a fixed number of cycles. Only after that does it drop the oscillator and synthesizer enables. When the pin is released, the block turns the oscillator and synthesizer back on and counts out a programmable stabilization window. It opens the clock gates only after that window ends. If power-down is requested again during the window, the block returns straight to the off state.

The block runs one state machine with four named states, and the current state appears on `seq_state` with this encoding: RUN=0, PARK=1, OSC_OFF=2, WAKE=3. The transitions are:
- RUN→PARK on a synchronized request.
- PARK→OSC_OFF after `PARK_CYCLES` cycles.
- OSC_OFF→WAKE on a synchronized release.
- WAKE→RUN after `WAKE_CYCLES` cycles.
- WAKE→OSC_OFF on a fresh request.
- Reset enters WAKE, so the power-on path is the same as a wake-up.

Two mode straps are captured only on the first clock edge after reset: the processor frequency select and the active-low spread enable. From the frequency strap and a live, active-low quarter-rate input, the block produces the divide ratios for the processor and bus clocks. These ratios are taken from a 400 MHz synthesizer.

Top module: `clkgen_pwrseq`

## Requirements
- R1: The power-down pin acts only through a two-stage synchronizer. After the first rising edge that samples it low, all outputs are unchanged. The second rising edge that samples it low drops the clock enables.
- R2: `cpu_clk_en`, `bus_clk_en` and `ref_clk_en` are low after the second rising edge at which the pin is sampled low, which is less than 3 processor cycles. The state is still RUN at that point.
- R3: After a request, the state is PARK for `PARK_CYCLES` edges, with the clocks low and `osc_en`/`pll_en` high. Only then does it enter OSC_OFF, where `osc_en` and `pll_en` are low. The oscillator enable never falls while a clock enable is high.
- R4: While the state is RUN with no request pending, `cpu_clk_en` follows `cpu_hold_n` and `bus_clk_en` follows `bus_hold_n`. In any other state, both hold inputs have no effect and the enables stay low.
- R5: On release, WAKE (state 3) is entered on the third edge after the pin is sampled high, with `osc_en` and `pll_en` high and the clocks still low. RUN and the clock enables follow exactly `WAKE_CYCLES` edges later.
- R6: A request during WAKE moves the state to OSC_OFF without passing through RUN. No clock enable goes high on that path.
- R7: Reset puts the state in WAKE with `osc_en` and `pll_en` high and all clock enables low. RUN is reached on the `WAKE_CYCLES`-th edge after reset is released.
- R8: `strap_fast` and `strap_spread_n` are captured on the first edge after reset and then ignored until the next reset. `spread_en` is the inverse of the captured `strap_spread_n`.
- R9: `cpu_div` is 4 when the captured `strap_fast` is 1 (100 MHz) and 6 when it is 0 (66.6 MHz). `bus_div` is 12 (33.3 MHz) in both cases. When `quarter_n` is low, both ratios are multiplied by 4. A change in `quarter_n` shows on the ratios one edge later.
- R10: `ref_clk_en` is high only in RUN with no request pending, and it does not depend on the hold inputs.
- R11: `cpu_clk_en` and `bus_clk_en` are never high unless `osc_en` and `pll_en` are both high. RUN is entered only from WAKE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal processor-domain clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwrdn_n | input | 1 | Asynchronous active-low power-down pin |
| cpu_hold_n | input | 1 | Synchronous active-low processor clock stop |
| bus_hold_n | input | 1 | Synchronous active-low bus clock stop |
| quarter_n | input | 1 | Active-low quarter-rate mode select |
| strap_fast | input | 1 | Frequency strap: 1 selects 100 MHz, 0 selects 66.6 MHz |
| strap_spread_n | input | 1 | Active-low spread-spectrum strap |
| cpu_clk_en | output | 1 | Gate enable for the processor clocks |
| bus_clk_en | output | 1 | Gate enable for the gated bus clocks |
| ref_clk_en | output | 1 | Gate enable for the reference clock |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | Synthesizer enable |
| spread_en | output | 1 | Latched 0.5 % down-spread enable |
| cpu_div | output | DIV_W | Processor clock divide ratio |
| bus_div | output | DIV_W | Bus clock divide ratio |
| seq_state | output | 2 | Sequencer state (RUN=0, PARK=1, OSC_OFF=2, WAKE=3) |

## Verification
The latency property takes for granted that the power-down pin is sampled at clock edges, so a level held across two consecutive edges counts as a request. It also assumes the hold inputs are already synchronous to `clk`, and that `WAKE_CYCLES` and `PARK_CYCLES` are at least 2. The stimulus changes every input one time unit after a rising edge. It keeps each power-down level for many cycles, except where the WAKE abort is tested on purpose. It holds the straps steady across the capture edge and only changes them afterwards, to show that they are ignored.

// File: rtl/clkgen_pwrseq_pkg.sv
package clkgen_pwrseq_pkg;
    typedef enum logic [1:0] {
        SEQ_RUN     = 2'd0,
        SEQ_PARK    = 2'd1,
        SEQ_OSC_OFF = 2'd2,
        SEQ_WAKE    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/clkgen_pd_sync.sv
module clkgen_pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b1;
                    else        chain_q[gi] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b1;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/clkgen_strap_capture.sv
module clkgen_strap_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_fast,
    input  logic strap_spread_n,
    output logic fast_lat,
    output logic spread_lat
);
    logic open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q     <= 1'b1;
            fast_lat   <= 1'b0;
            spread_lat <= 1'b0;
        end else if (open_q) begin
            open_q     <= 1'b0;
            fast_lat   <= strap_fast;
            spread_lat <= ~strap_spread_n;
        end
    end
endmodule

// File: rtl/clkgen_ratio_sel.sv
module clkgen_ratio_sel #(
    parameter int DIV_W        = 6,
    parameter int CPU_DIV_FAST = 4,
    parameter int CPU_DIV_SLOW = 6,
    parameter int BUS_DIV      = 12,
    parameter int QUARTER_MUL  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast,
    input  logic             quarter_n,
    output logic [DIV_W-1:0] cpu_div,
    output logic [DIV_W-1:0] bus_div
);
    localparam logic [DIV_W-1:0] CPU_F  = DIV_W'(CPU_DIV_FAST);
    localparam logic [DIV_W-1:0] CPU_S  = DIV_W'(CPU_DIV_SLOW);
    localparam logic [DIV_W-1:0] CPU_FQ = DIV_W'(CPU_DIV_FAST * QUARTER_MUL);
    localparam logic [DIV_W-1:0] CPU_SQ = DIV_W'(CPU_DIV_SLOW * QUARTER_MUL);
    localparam logic [DIV_W-1:0] BUS_N  = DIV_W'(BUS_DIV);
    localparam logic [DIV_W-1:0] BUS_Q  = DIV_W'(BUS_DIV * QUARTER_MUL);

    logic quarter_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) quarter_q <= 1'b0;
        else        quarter_q <= ~quarter_n;
    end

    always_comb begin
        unique case ({fast, quarter_q})
            2'b10:   cpu_div = CPU_F;
            2'b11:   cpu_div = CPU_FQ;
            2'b00:   cpu_div = CPU_S;
            default: cpu_div = CPU_SQ;
        endcase
        bus_div = quarter_q ? BUS_Q : BUS_N;
    end
endmodule

// File: rtl/clkgen_pwrseq.sv
module clkgen_pwrseq
    import clkgen_pwrseq_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int PARK_CYCLES  = 2,
    parameter int WAKE_CYCLES  = 750000,
    parameter int DIV_W        = 6,
    parameter int CPU_DIV_FAST = 4,
    parameter int CPU_DIV_SLOW = 6,
    parameter int BUS_DIV      = 12,
    parameter int QUARTER_MUL  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwrdn_n,
    input  logic             cpu_hold_n,
    input  logic             bus_hold_n,
    input  logic             quarter_n,
    input  logic             strap_fast,
    input  logic             strap_spread_n,
    output logic             cpu_clk_en,
    output logic             bus_clk_en,
    output logic             ref_clk_en,
    output logic             osc_en,
    output logic             pll_en,
    output logic             spread_en,
    output logic [DIV_W-1:0] cpu_div,
    output logic [DIV_W-1:0] bus_div,
    output logic [1:0]       seq_state
);
    localparam int CNT_MAX = (WAKE_CYCLES > PARK_CYCLES) ? WAKE_CYCLES : PARK_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] PARK_LAST = CNT_W'(PARK_CYCLES - 1);
    localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYCLES - 1);

    seq_state_e       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             pd_sync, pd_req, run_ok, fast_lat;

    clkgen_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pwrdn_n),
        .sync_out (pd_sync)
    );
    assign pd_req = ~pd_sync;

    clkgen_strap_capture u_straps (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_fast     (strap_fast),
        .strap_spread_n (strap_spread_n),
        .fast_lat       (fast_lat),
        .spread_lat     (spread_en)
    );

    clkgen_ratio_sel #(
        .DIV_W        (DIV_W),
        .CPU_DIV_FAST (CPU_DIV_FAST),
        .CPU_DIV_SLOW (CPU_DIV_SLOW),
        .BUS_DIV      (BUS_DIV),
        .QUARTER_MUL  (QUARTER_MUL)
    ) u_ratio (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast      (fast_lat),
        .quarter_n (quarter_n),
        .cpu_div   (cpu_div),
        .bus_div   (bus_div)
    );

    // State register: reset enters WAKE so power-on follows the wake path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_WAKE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            SEQ_RUN: begin
                if (pd_req) begin
                    state_nx = SEQ_PARK;
                    cnt_nx   = '0;
                end
            end
            SEQ_PARK: begin
                if (cnt_q == PARK_LAST) begin
                    state_nx = SEQ_OSC_OFF;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            SEQ_OSC_OFF: begin
                if (!pd_req) begin
                    state_nx = SEQ_WAKE;
                    cnt_nx   = '0;
                end
            end
            SEQ_WAKE: begin
                if (pd_req) begin
                    state_nx = SEQ_OSC_OFF;
                    cnt_nx   = '0;
                end else if (cnt_q == WAKE_LAST) begin
                    state_nx = SEQ_RUN;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            default: begin
                state_nx = SEQ_WAKE;
                cnt_nx   = '0;
            end
        endcase
    end

    // Output decode: gates drop as soon as the synchronized request appears.
    always_comb begin
        osc_en = 1'b1;
        pll_en = 1'b1;
        run_ok = 1'b0;
        unique case (state_q)
            SEQ_RUN:     run_ok = ~pd_req;
            SEQ_PARK:    run_ok = 1'b0;
            SEQ_OSC_OFF: begin
                osc_en = 1'b0;
                pll_en = 1'b0;
            end
            SEQ_WAKE:    run_ok = 1'b0;
            default:     run_ok = 1'b0;
        endcase
        cpu_clk_en = run_ok & cpu_hold_n;
        bus_clk_en = run_ok & bus_hold_n;
        ref_clk_en = run_ok;
        seq_state  = state_q;
    end
endmodule

// File: rtl/clkgen_pwrseq_chk.sv
module clkgen_pwrseq_chk #(
    parameter int DIV_W        = 6,
    parameter int CPU_DIV_FAST = 4,
    parameter int CPU_DIV_SLOW = 6,
    parameter int QUARTER_MUL  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwrdn_n,
    input logic             cpu_clk_en,
    input logic             bus_clk_en,
    input logic             ref_clk_en,
    input logic             osc_en,
    input logic             pll_en,
    input logic             spread_en,
    input logic [DIV_W-1:0] cpu_div,
    input logic [1:0]       seq_state
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R3
    park_before_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> ($past(cpu_clk_en) == 1'b0 && $past(bus_clk_en) == 1'b0));

    // R2
    entry_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q[1] && !$past(pwrdn_n) && !$past(pwrdn_n, 2))
            |-> (!cpu_clk_en && !bus_clk_en && !ref_clk_en));

    // R11
    clocks_need_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en || bus_clk_en || ref_clk_en) |-> (osc_en && pll_en));

    // R11
    run_from_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd0 && $past(seq_state) != 2'd0) |-> $past(seq_state) == 2'd3);

    // R8
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        age_q[1] |-> $stable(spread_en));

    // R9
    ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_div == DIV_W'(CPU_DIV_FAST) || cpu_div == DIV_W'(CPU_DIV_SLOW) ||
         cpu_div == DIV_W'(CPU_DIV_FAST * QUARTER_MUL) ||
         cpu_div == DIV_W'(CPU_DIV_SLOW * QUARTER_MUL)));
endmodule

bind clkgen_pwrseq clkgen_pwrseq_chk #(
    .DIV_W        (DIV_W),
    .CPU_DIV_FAST (CPU_DIV_FAST),
    .CPU_DIV_SLOW (CPU_DIV_SLOW),
    .QUARTER_MUL  (QUARTER_MUL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwrdn_n    (pwrdn_n),
    .cpu_clk_en (cpu_clk_en),
    .bus_clk_en (bus_clk_en),
    .ref_clk_en (ref_clk_en),
    .osc_en     (osc_en),
    .pll_en     (pll_en),
    .spread_en  (spread_en),
    .cpu_div    (cpu_div),
    .seq_state  (seq_state)
);

// File: tb/clkgen_pwrseq_bench.sv
module clkgen_pwrseq_bench;
    localparam int PARK = 2;
    localparam int WAKE = 20;
    localparam int DW   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrdn_n = 1'b1, cpu_hold_n = 1'b1, bus_hold_n = 1'b1;
    logic quarter_n = 1'b1, strap_fast = 1'b0, strap_spread_n = 1'b1;
    logic cpu_clk_en, bus_clk_en, ref_clk_en, osc_en, pll_en, spread_en;
    logic [DW-1:0] cpu_div, bus_div;
    logic [1:0] seq_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clkgen_pwrseq #(.PARK_CYCLES(PARK), .WAKE_CYCLES(WAKE), .DIV_W(DW)) u_clkgen_pwrseq (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .cpu_hold_n(cpu_hold_n),
        .bus_hold_n(bus_hold_n), .quarter_n(quarter_n), .strap_fast(strap_fast),
        .strap_spread_n(strap_spread_n), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
        .ref_clk_en(ref_clk_en), .osc_en(osc_en), .pll_en(pll_en), .spread_en(spread_en),
        .cpu_div(cpu_div), .bus_div(bus_div), .seq_state(seq_state));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // gates packed as {cpu,bus,ref}, supplies as {osc,pll}
    function automatic int gates();
        return {29'd0, cpu_clk_en, bus_clk_en, ref_clk_en};
    endfunction
    function automatic int supplies();
        return {30'd0, osc_en, pll_en};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int cfg = 0; cfg < 8; cfg++) begin
            int fast, spr_n, q_n, mul;
            fast = cfg & 1; spr_n = (cfg >> 1) & 1; q_n = (cfg >> 2) & 1;
            mul = q_n ? 1 : 4;
            rst_n = 1'b0; pwrdn_n = 1'b1; cpu_hold_n = 1'b1; bus_hold_n = 1'b1;
            strap_fast = fast[0]; strap_spread_n = spr_n[0]; quarter_n = q_n[0];
            step(2);
            // R7 reset state
            check("R7 reset state", seq_state, 3);
            check("R7 reset supplies", supplies(), 3);
            check("R7 reset gates", gates(), 0);
            rst_n = 1'b1;
            step(1);
            strap_fast = ~strap_fast; strap_spread_n = ~strap_spread_n;
            step(WAKE - 2);
            check("R7 still waking", seq_state, 3);
            step(1);
            check("R7 run after wake count", seq_state, 0);
            check("R7 gates open", gates(), 7);
            // R8 straps captured at first edge, later change ignored
            check("R8 spread", spread_en, 1 - spr_n);
            // R9 ratios
            check("R9 cpu ratio", cpu_div, (fast ? 4 : 6) * mul);
            check("R9 bus ratio", bus_div, 12 * mul);
            quarter_n = ~quarter_n;
            check("R9 ratio before edge", cpu_div, (fast ? 4 : 6) * mul);
            step(1);
            mul = quarter_n ? 1 : 4;
            check("R9 cpu ratio live", cpu_div, (fast ? 4 : 6) * mul);
            check("R9 bus ratio live", bus_div, 12 * mul);
            // R4 / R10 hold inputs in RUN
            cpu_hold_n = 1'b0; #1;
            check("R4 cpu hold", gates(), 3);
            bus_hold_n = 1'b0; cpu_hold_n = 1'b1; #1;
            check("R4 bus hold, R10 ref kept", gates(), 5);
            bus_hold_n = 1'b1;
            // power-down entry
            step(1);
            pwrdn_n = 1'b0;
            step(1);
            check("R1 first edge ignored", gates(), 7);
            step(1);
            check("R2 gates low by second edge", gates(), 0);
            check("R2 state still run", seq_state, 0);
            step(PARK);
            check("R3 park state", seq_state, 1);
            check("R3 supplies on in park", supplies(), 3);
            step(1);
            check("R3 osc off", seq_state, 2);
            check("R3 supplies off", supplies(), 0);
            // R4 holds are don't care while off
            cpu_hold_n = 1'b0; bus_hold_n = 1'b0; step(1);
            cpu_hold_n = 1'b1; bus_hold_n = 1'b1; #1;
            check("R4 holds ignored off", gates(), 0);
            check("R10 ref off", ref_clk_en, 0);
            // release
            pwrdn_n = 1'b1;
            step(2);
            check("R5 off until sync", seq_state, 2);
            step(1);
            check("R5 wake entered", seq_state, 3);
            check("R5 supplies on", supplies(), 3);
            check("R5 gates closed", gates(), 0);
            if (cfg[0]) begin
                // R6 abort during wake
                step(3);
                pwrdn_n = 1'b0;
                step(2);
                check("R6 wake before abort", seq_state, 3);
                step(1);
                check("R6 abort to off", seq_state, 2);
                check("R6 gates closed", gates(), 0);
                pwrdn_n = 1'b1;
                step(3);
                check("R6 rewake", seq_state, 3);
            end
            step(WAKE - 1);
            check("R5 still waking", seq_state, 3);
            check("R5 gates held", gates(), 0);
            step(1);
            check("R5 run", seq_state, 0);
            check("R5 gates released", gates(), 7);
            check("R8 spread after cycle", spread_en, 1 - spr_n);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule